// File: doc/BRIEF.md
# Sample History Queue with 60 Hz Notch Output

This block keeps a short history of signed samples in a queue that is always full. When a sample strobe arrives, the new sample becomes the newest entry, every older entry moves back one place, and the oldest entry is dropped. The queue never reports empty or full and never refuses a write.

A consumer can read any entry at any time by giving its position. Position 0 is the newest sample and position DEPTH-1 is the oldest. Reading never changes the contents.

A fixed filter stage uses the same history. It produces `y = (v0 + v3) / 2`, where v0 is the newest sample and v3 is the sample three steps older. At a 360 Hz sample rate this response has zeros at 60 Hz and 180 Hz. The result comes out one clock after each sample strobe, together with a one-cycle valid pulse. DEPTH must be a power of two and at least 4.

Top module: `macq_notch`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every history entry reads as zero, `filt_valid` is 0 and `filt_data` is 0.
- R2: A clock edge with `smp_valid` high places `smp_data` at position 0. Every entry at position i moves to position i+1, and the entry at position DEPTH-1 is lost.
- R3: A clock edge with `smp_valid` low leaves every entry unchanged.
- R4: `rd_data` shows the entry at position `rd_idx` combinationally, in the same cycle, and reading never alters the contents. In a cycle where a write is also pending, `rd_data` shows the contents from before that write.
- R5: `filt_valid` is high for exactly the one cycle after each clock edge at which `smp_valid` was high, and low otherwise.
- R6: When `filt_valid` is high, `filt_data` equals floor((v0 + v3) / 2), taken over the history after the write. The sum is formed with one guard bit (13 bits for 12-bit samples) and halved by an arithmetic right shift, so odd negative sums round toward minus infinity.
- R7: `filt_data` keeps its last value through cycles that have no sample strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Signed sample |
| rd_idx | input | log2(DEPTH) | Read position, 0 = newest |
| rd_data | output | DATA_W | Signed entry at `rd_idx` |
| filt_data | output | DATA_W | Signed notch filter result |
| filt_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
A random-access read and a queue write can fall in the same cycle. The bench provokes this by holding `smp_valid` high with a read position set. While the strobe is still asserted, before the edge, it checks that `rd_data` shows the old entry. After the edge it sweeps every position and checks that the whole history has shifted, and that the filter result matches a sum formed from the new head.

// File: rtl/macq_notch.sv
module macq_notch #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp_data,
  input  logic        [IDX_W-1:0]  rd_idx,
  output logic signed [DATA_W-1:0] rd_data,
  output logic signed [DATA_W-1:0] filt_data,
  output logic                     filt_valid
);

  logic [DEPTH-1:0][DATA_W-1:0] hist;
  logic [DATA_W:0]              sum_nx;

  assign sum_nx  = {smp_data[DATA_W-1], smp_data} + {hist[2][DATA_W-1], hist[2]};
  assign rd_data = hist[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist       <= '0;
      filt_data  <= '0;
      filt_valid <= 1'b0;
    end else begin
      filt_valid <= smp_valid;
      if (smp_valid) begin
        hist      <= {hist[DEPTH-2:0], smp_data};
        filt_data <= sum_nx[DATA_W:1];
      end
    end
  end

  logic [DATA_W:0] sum_now;
  assign sum_now = {hist[0][DATA_W-1], hist[0]} + {hist[3][DATA_W-1], hist[3]};

  assert_head_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> hist[0] == $past(smp_data));
  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> hist[DEPTH-1] == $past(hist[DEPTH-2]));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(hist));
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> filt_valid);
  assert_valid_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !filt_valid);
  assert_filter_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    filt_valid |-> ({filt_data, 1'b0} == sum_now) || ({filt_data, 1'b1} == sum_now));
  assert_filter_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(filt_data));

endmodule

// File: tb/macq_notch_tb.sv
module macq_notch_tb;
  localparam int DATA_W = 12;
  localparam int DEPTH  = 4;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     smp_valid = 1'b0;
  logic signed [DATA_W-1:0] smp_data = '0;
  logic        [1:0]        rd_idx = '0;
  logic signed [DATA_W-1:0] rd_data, filt_data;
  logic                     filt_valid;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  int model [DEPTH];
  int last_filt = 0;

  always #4 clk = ~clk;

  macq_notch #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .filt_data(filt_data), .filt_valid(filt_valid));

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < DEPTH; i++) begin
      rd_idx = 2'(i);
      #1;
      check(req, int'(rd_data), model[i]);
    end
  endtask

  function automatic int floor_half(input int s);
    return (s < 0 && (s % 2) != 0) ? (s - 1) / 2 : s / 2;
  endfunction

  task automatic push(input int v, input int k);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = DATA_W'(v);
    rd_idx    = 2'(k % DEPTH);
    #1;
    check("R4 pre-write read", int'(rd_data), model[k % DEPTH]);
    @(posedge clk);
    for (int i = DEPTH - 1; i > 0; i--) model[i] = model[i-1];
    model[0] = v;
    last_filt = floor_half(model[0] + model[3]);
    @(negedge clk);
    smp_valid = 1'b0;
    check("R5 valid after strobe", int'(filt_valid), 1);
    check("R6 filter value", int'(filt_data), last_filt);
    sweep("R2 shifted history");
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      check("R5 no pulse when idle", int'(filt_valid), 0);
      check("R7 filter held", int'(filt_data), last_filt);
      sweep("R3 history held");
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(filt_valid), 0);
    check("R1 filter in reset", int'(filt_data), 0);
    sweep("R1 history in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(filt_valid), 0);
    sweep("R1 history after reset");
    // zero-filled history: first outputs use zeros for v3
    push(7, 0);
    push(-5, 1);
    push(2047, 2);
    push(2047, 3);
    push(-2048, 0);
    push(-2048, 1);
    push(-2048, 2);
    push(-2048, 3);
    push(2047, 0);
    push(-1, 1);
    push(0, 2);
    idle(3);
    begin
      int seed = 12345;
      for (int k = 0; k < 600; k++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        push(((seed >>> 8) % 4096) - 2048, k);
        if (k % 37 == 0) idle(1 + k % 3);
      end
    end
    // odd negative sums round toward minus infinity
    push(-3, 0); push(0, 1); push(0, 2); push(0, 3);
    for (int a = -2048; a < 2048; a += 97) push(a, a & 3);
    idle(2);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule